// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave side of a serial peripheral bus for a small byte-addressed nonvolatile store. A host drives a serial clock, an active-low select, a data input line and two control lines (pause and write-inhibit). The block decodes one-byte commands, an address byte and data bytes, and returns read data and a status byte on its serial output. The storage is a register array. The programming delay of a real cell is modelled by a cycle counter that runs after the host releases the select line.

All serial pins are brought into the block's system clock domain through a synchronizer chain. Serial clock edges are found by comparing successive synchronized samples. Input bits are taken on rising serial-clock edges and output bits are launched on falling edges, so the block works with bus modes 0 and 3. Writes need a prior write-enable command. They are screened against a protected top region chosen by two status bits, and they start the internal cycle only when the select line rises at a clean byte boundary.

Top module: `spi_nvm_slave`

## Requirements
- R1: After reset the output enable is low, the standby flag is high, the status byte reads 0xF0 and every array byte reads 0x00.
- R2: The status byte is {1111, PROT1, PROT0, WEL, RDY} with RDY in bit 0 and WEL in bit 1. Command 0x06 sets WEL and command 0x04 clears it.
- R3: Command 0x03 followed by an address byte returns the byte at that address MSB first. Each output bit changes only after a falling serial-clock edge. Further bytes follow from successive addresses, wrapping from the last address to 0x00.
- R4: Command 0x02 with an address byte and exactly one data byte, sent while WEL is set, updates the array only after the select line rises and the write timer of WRITE_CYCLES clocks expires. WEL is clear afterwards.
- R5: While the write timer runs, RDY reads 1, and every command other than 0x05 is ignored.
- R6: A write command sent while WEL is clear changes nothing and starts no timer.
- R7: Command 0x01 with one data byte, sent while WEL is set, loads data bits 3:2 into PROT1:PROT0 when its timer expires.
- R8: With a 128-byte array, PROT=01 protects 0x60-0x7F, PROT=10 protects 0x40-0x7F and PROT=11 protects 0x00-0x7F. A write to a protected address leaves the array unchanged, starts no timer and clears WEL.
- R9: Write-inhibit low blocks write and status-write commands, and abandons such a sequence already in progress, clearing WEL. Write-inhibit going low after the timer has started does not stop the write.
- R10: Pause taken low while the serial clock is low drops the output enable and ignores serial clock and data until pause is released with the clock low. The transaction then continues unchanged.
- R11: While select is high, the output enable is low. A write sequence that carries bits beyond its last complete byte is discarded and clears WEL.
- R12: The standby flag is high only while select is high and no write timer is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| wp_n | input | 1 | Active-low write-inhibit |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for serial data out |
| standby | output | 1 | Idle flag: select high and no write timer running |

## Verification
The assertions assume that every serial pin is stable for more cycles than the synchronizer latency plus one. They also assume that the pause and select lines change only while the serial clock is low. Under these conditions, each serial-clock edge is seen as exactly one rising or falling event in the system domain. The stimulus meets this by driving all pins on the falling system-clock edge. It holds each serial-clock phase for six system cycles, and it moves select and pause only after the clock has returned low.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

    localparam logic [7:0] CMD_WEN   = 8'h06;
    localparam logic [7:0] CMD_WDIS  = 8'h04;
    localparam logic [7:0] CMD_STRD  = 8'h05;
    localparam logic [7:0] CMD_STWR  = 8'h01;
    localparam logic [7:0] CMD_RD    = 8'h03;
    localparam logic [7:0] CMD_WR    = 8'h02;

    typedef enum logic [3:0] {
        PH_OPC,   // collecting the command byte
        PH_ADDR,  // collecting the address byte
        PH_WDAT,  // collecting the write data byte
        PH_WEND,  // write data complete, waiting for select release
        PH_SWR,   // collecting the status data byte
        PH_SEND,  // status data complete, waiting for select release
        PH_RD,    // streaming array data
        PH_SRD,   // streaming the status byte
        PH_SKIP   // ignore the rest of this selection
    } phase_e;

    typedef struct packed {
        phase_e      phase;
        logic [2:0]  bcnt;
        logic [6:0]  sh;
        logic [7:0]  osh;
        logic        sob;
        logic        oe;
        logic        hold;
        logic        sck_p;
        logic        cs_p;
        logic        is_rd;
        logic [7:0]  addr;
        logic        wel;
        logic [1:0]  prot;
        logic        pend_st;
        logic [7:0]  paddr;
        logic [7:0]  pdat;
    } ctrl_st_t;

    // Top-region protection test, selected by the two protect bits.
    function automatic logic addr_locked(input logic [1:0] prot,
                                         input logic [7:0] a,
                                         input int unsigned aw);
        logic [1:0] top;
        top = 2'((a >> (aw - 2)) & 8'd3);
        case (prot)
            2'b00:   return 1'b0;
            2'b01:   return top == 2'b11;
            2'b10:   return top[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
    parameter int unsigned WIDTH = 5,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_nvm_array.sv
module spi_nvm_array #(
    parameter int unsigned ADDR_W = 7,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [7:0]        wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [7:0]        rdata_o
);

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[waddr_i] = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/spi_nvm_wtimer.sv
module spi_nvm_wtimer #(
    parameter int unsigned WRITE_CYCLES = 1000,
    localparam int unsigned CW = $clog2(WRITE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam logic [CW-1:0] LAST = CW'(WRITE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          busy_d, busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        done_o = 1'b0;
        if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_d = 1'b0;
                done_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end else if (start_i) begin
            busy_d = 1'b1;
            cnt_d  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl
    import spi_nvm_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              csn_i,
    input  logic              si_i,
    input  logic              holdn_i,
    input  logic              wpn_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [7:0]        rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [7:0]        wdata_o,
    output logic              start_o,
    output logic              so_o,
    output logic              so_oe_o,
    output logic [1:0]        prot_o
);

    localparam logic [7:0] AMASK = 8'((9'd1 << ADDR_W) - 9'd1);
    localparam ctrl_st_t ST_RST = '{phase: PH_SKIP, default: '0};

    ctrl_st_t q, n;
    logic       cs_act, cs_fall_ev, cs_rise_ev;
    logic       rise, fall, byte_done, wr_phase, hold_base;
    logic [7:0] byt, status, rd_addr8;

    assign cs_act     = !csn_i;
    assign cs_fall_ev = cs_act && !q.cs_p;
    assign cs_rise_ev = !cs_act && q.cs_p;
    assign rise       = sck_i && !q.sck_p;
    assign fall       = !sck_i && q.sck_p;
    assign byt        = {q.sh, si_i};
    assign byte_done  = (q.bcnt == 3'd7);
    assign status     = {4'hF, q.prot, q.wel, busy_i};
    assign wr_phase   = (q.phase == PH_WDAT) || (q.phase == PH_WEND) ||
                        (q.phase == PH_SWR)  || (q.phase == PH_SEND) ||
                        ((q.phase == PH_ADDR) && !q.is_rd);

    // Read address: the incoming address byte, or the next sequential one.
    always_comb begin
        if (q.phase == PH_ADDR) rd_addr8 = byt & AMASK;
        else                    rd_addr8 = (q.addr + 8'd1) & AMASK;
    end

    always_comb begin
        n       = q;
        n.sck_p = sck_i;
        n.cs_p  = cs_act;
        start_o = 1'b0;
        we_o    = 1'b0;
        hold_base = cs_fall_ev ? 1'b0 : q.hold;

        if (cs_rise_ev) begin
            if (q.phase == PH_WEND && !busy_i) begin
                if (addr_locked(q.prot, q.paddr, ADDR_W)) begin
                    n.wel = 1'b0;
                end else begin
                    start_o   = 1'b1;
                    n.pend_st = 1'b0;
                end
            end else if (q.phase == PH_SEND && !busy_i) begin
                start_o   = 1'b1;
                n.pend_st = 1'b1;
            end else if (wr_phase) begin
                n.wel = 1'b0;
            end
            n.phase = PH_SKIP;
            n.hold  = 1'b0;
        end else if (cs_act) begin
            if (cs_fall_ev) begin
                n.phase = PH_OPC;
                n.bcnt  = 3'd0;
            end
            n.hold = hold_base;
            if (!hold_base && !holdn_i && !sck_i)     n.hold = 1'b1;
            else if (hold_base && holdn_i && !sck_i)  n.hold = 1'b0;

            if (!cs_fall_ev && !wpn_i && wr_phase) begin
                n.phase = PH_SKIP;
                n.wel   = 1'b0;
            end else if (!cs_fall_ev && rise && !q.hold) begin
                n.sh   = byt[6:0];
                n.bcnt = q.bcnt + 3'd1;
                case (q.phase)
                    PH_OPC: if (byte_done) begin
                        n.phase = PH_SKIP;
                        if (!busy_i || byt == CMD_STRD) begin
                            case (byt)
                                CMD_WEN:  n.wel = 1'b1;
                                CMD_WDIS: n.wel = 1'b0;
                                CMD_STRD: begin
                                    n.phase = PH_SRD;
                                    n.osh   = status;
                                end
                                CMD_RD: begin
                                    n.phase = PH_ADDR;
                                    n.is_rd = 1'b1;
                                end
                                CMD_WR: begin
                                    if (q.wel && wpn_i) begin
                                        n.phase = PH_ADDR;
                                        n.is_rd = 1'b0;
                                    end else begin
                                        n.wel = 1'b0;
                                    end
                                end
                                CMD_STWR: begin
                                    if (q.wel && wpn_i) n.phase = PH_SWR;
                                    else                n.wel = 1'b0;
                                end
                                default: n.phase = PH_SKIP;
                            endcase
                        end
                    end
                    PH_ADDR: if (byte_done) begin
                        n.addr = byt & AMASK;
                        if (q.is_rd) begin
                            n.phase = PH_RD;
                            n.osh   = rd_data_i;
                        end else begin
                            n.phase = PH_WDAT;
                        end
                    end
                    PH_WDAT: if (byte_done) begin
                        n.paddr = q.addr;
                        n.pdat  = byt;
                        n.phase = PH_WEND;
                    end
                    PH_SWR: if (byte_done) begin
                        n.pdat  = byt;
                        n.phase = PH_SEND;
                    end
                    PH_WEND, PH_SEND: begin
                        n.phase = PH_SKIP;
                        n.wel   = 1'b0;
                    end
                    PH_RD: if (byte_done) begin
                        n.addr = rd_addr8;
                        n.osh  = rd_data_i;
                    end
                    PH_SRD: if (byte_done) n.osh = status;
                    default: ;
                endcase
            end else if (!cs_fall_ev && fall && !q.hold &&
                         (q.phase == PH_RD || q.phase == PH_SRD)) begin
                n.sob = q.osh[7];
                n.osh = {q.osh[6:0], 1'b0};
            end
        end

        n.oe = cs_act && !n.hold;

        if (done_i) begin
            if (q.pend_st) n.prot = q.pdat[3:2];
            else           we_o   = 1'b1;
            n.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RST;
        else        q <= n;
    end

    assign rd_addr_o = rd_addr8[ADDR_W-1:0];
    assign waddr_o   = q.paddr[ADDR_W-1:0];
    assign wdata_o   = q.pdat;
    assign so_o      = q.sob;
    assign so_oe_o   = q.oe;
    assign prot_o    = q.prot;

endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
    parameter int unsigned ADDR_W       = 7,
    parameter int unsigned WRITE_CYCLES = 1000,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe,
    output logic standby
);

    logic [4:0]        pins_s;
    logic              sck_s, csn_s, si_s, holdn_s, wpn_s;
    logic              busy, done, start, we;
    logic [ADDR_W-1:0] raddr, waddr;
    logic [7:0]        rdata, wdata;
    logic [1:0]        prot;

    spi_nvm_sync #(
        .WIDTH   (5),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (5'b01011)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck, cs_n, si, hold_n, wp_n}),
        .q_o   (pins_s)
    );

    assign {sck_s, csn_s, si_s, holdn_s, wpn_s} = pins_s;

    spi_nvm_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_i     (sck_s),
        .csn_i     (csn_s),
        .si_i      (si_s),
        .holdn_i   (holdn_s),
        .wpn_i     (wpn_s),
        .busy_i    (busy),
        .done_i    (done),
        .rd_data_i (rdata),
        .rd_addr_o (raddr),
        .we_o      (we),
        .waddr_o   (waddr),
        .wdata_o   (wdata),
        .start_o   (start),
        .so_o      (so),
        .so_oe_o   (so_oe),
        .prot_o    (prot)
    );

    spi_nvm_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) i_wtimer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    spi_nvm_array #(.ADDR_W(ADDR_W)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    assign standby = csn_s && !busy;

endmodule

// File: rtl/spi_nvm_checker.sv
module spi_nvm_checker #(
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csn_s,
    input logic              sck_s,
    input logic              holdn_s,
    input logic              so,
    input logic              so_oe,
    input logic              busy,
    input logic              we,
    input logic [ADDR_W-1:0] waddr,
    input logic [1:0]        prot
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic in_region;
    always_comb begin
        case (prot)
            2'b00:   in_region = 1'b0;
            2'b01:   in_region = int'(waddr) >= (DEPTH - DEPTH / 4);
            2'b10:   in_region = int'(waddr) >= (DEPTH / 2);
            default: in_region = 1'b1;
        endcase
    end

    assert_oe_off_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csn_s) |-> !so_oe);

    assert_so_moves_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so != $past(so))) |-> ($past(sck_s, 2) && !$past(sck_s)));

    assert_pause_drops_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!csn_s && !holdn_s && !sck_s) && !csn_s) |-> !so_oe);

    assert_timer_starts_on_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(csn_s));

    assert_no_locked_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !in_region);

endmodule

bind spi_nvm_slave spi_nvm_checker #(.ADDR_W(ADDR_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .csn_s   (csn_s),
    .sck_s   (sck_s),
    .holdn_s (holdn_s),
    .so      (so),
    .so_oe   (so_oe),
    .busy    (busy),
    .we      (we),
    .waddr   (waddr),
    .prot    (prot)
);

// File: tb/test_spi_nvm_slave.sv
module test_spi_nvm_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WCYC       = 1000;
    localparam int WAIT_W     = WCYC + 60;

    // {prot[1:0], addr[7:0], data[7:0], expect_written}
    localparam logic [18:0] VEC [8] = '{
        {2'b00, 8'h10, 8'hA5, 1'b1},
        {2'b01, 8'h60, 8'h11, 1'b0},
        {2'b01, 8'h5F, 8'h22, 1'b1},
        {2'b10, 8'h40, 8'h33, 1'b0},
        {2'b10, 8'h3F, 8'h44, 1'b1},
        {2'b11, 8'h00, 8'h55, 1'b0},
        {2'b11, 8'h7E, 8'h66, 1'b0},
        {2'b00, 8'h7E, 8'h77, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe, standby;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_nvm_slave #(.WRITE_CYCLES(WCYC)) i_spi_nvm_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .cs_n    (cs_n),
        .si      (si),
        .hold_n  (hold_n),
        .wp_n    (wp_n),
        .so      (so),
        .so_oe   (so_oe),
        .standby (standby)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic cs_lo();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_hi();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            wait_clk(HALF);
            rx[i] = so;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        cs_lo();
        xfer(op, r);
        cs_hi();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] r;
        cs_lo();
        xfer(8'h05, r);
        xfer(8'h00, st);
        cs_hi();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] r;
        cs_lo();
        xfer(8'h01, r);
        xfer(v, r);
        cs_hi();
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r;
        cs_lo();
        xfer(8'h02, r);
        xfer(a, r);
        xfer(d, r);
        cs_hi();
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        logic [7:0] r;
        cs_lo();
        xfer(8'h03, r);
        xfer(a, r);
        xfer(8'h00, d);
        cs_hi();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] st, d, d2;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R1: reset state
        check("R1 so_oe after reset", 32'(so_oe), 32'd0);
        check("R1 standby after reset", 32'(standby), 32'd1);
        rdsr(st);
        check("R1 status after reset", 32'(st), 32'hF0);
        rd(8'h20, d);
        check("R1 array byte after reset", 32'(d), 32'h00);

        // R2: enable latch set and clear
        cmd1(8'h06);
        rdsr(st);
        check("R2 status after enable", 32'(st), 32'hF2);
        cmd1(8'h04);
        rdsr(st);
        check("R2 status after disable", 32'(st), 32'hF0);

        // R7 R8 R4: protection table walk
        for (int k = 0; k < 8; k++) begin
            logic [1:0] pb;
            logic [7:0] va, vd;
            logic       ve;
            {pb, va, vd, ve} = VEC[k];
            cmd1(8'h06);
            wrsr({4'h0, pb, 2'b00});
            wait_clk(WAIT_W);
            rdsr(st);
            check("R7 protect bits loaded", 32'(st), 32'({4'hF, pb, 2'b00}));
            cmd1(8'h06);
            wr(va, vd);
            wait_clk(WAIT_W);
            rd(va, d);
            check(ve ? "R4 write committed" : "R8 locked write discarded",
                  32'(d), ve ? 32'(vd) : 32'h00);
            rdsr(st);
            check("R8 enable clear after write attempt", 32'(st), 32'({4'hF, pb, 2'b00}));
        end

        // R3: sequential read with wrap
        cmd1(8'h06);
        wr(8'h7F, 8'hC3);
        wait_clk(WAIT_W);
        cmd1(8'h06);
        wr(8'h00, 8'h3C);
        wait_clk(WAIT_W);
        cs_lo();
        xfer(8'h03, d);
        xfer(8'h7F, d);
        xfer(8'h00, d);
        xfer(8'h00, d2);
        cs_hi();
        check("R3 read last address", 32'(d), 32'hC3);
        check("R3 read wraps to 0x00", 32'(d2), 32'h3C);
        rd(8'h5F, d);
        check("R3 read single byte", 32'(d), 32'h22);

        // R6: write without enable
        cmd1(8'h04);
        wr(8'h20, 8'h99);
        rdsr(st);
        check("R6 no timer without enable", 32'(st), 32'hF0);
        rd(8'h20, d);
        check("R6 array unchanged without enable", 32'(d), 32'h00);

        // R5 R12: busy behaviour
        cmd1(8'h06);
        wr(8'h21, 8'h5A);
        check("R12 standby low while timer runs", 32'(standby), 32'd0);
        rdsr(st);
        check("R5 RDY and WEL during timer", 32'(st), 32'hF3);
        wr(8'h22, 8'hEE);
        wait_clk(WAIT_W);
        check("R12 standby high when idle", 32'(standby), 32'd1);
        rd(8'h21, d);
        check("R4 first write landed", 32'(d), 32'h5A);
        rd(8'h22, d);
        check("R5 command during timer ignored", 32'(d), 32'h00);
        rdsr(st);
        check("R4 enable clear after commit", 32'(st), 32'hF0);

        // R9: write-inhibit cases
        wp_n = 1'b0;
        cmd1(8'h06);
        wr(8'h23, 8'h12);
        wait_clk(WAIT_W);
        rd(8'h23, d);
        check("R9 inhibited write blocked", 32'(d), 32'h00);
        rdsr(st);
        check("R9 enable cleared by blocked write", 32'(st), 32'hF0);
        wp_n = 1'b1;
        cmd1(8'h06);
        cs_lo();
        xfer(8'h02, d);
        xfer(8'h24, d);
        wp_n = 1'b0;
        xfer(8'h34, d);
        cs_hi();
        wp_n = 1'b1;
        wait_clk(WAIT_W);
        rd(8'h24, d);
        check("R9 mid-sequence inhibit abandons write", 32'(d), 32'h00);
        rdsr(st);
        check("R9 enable cleared by abandon", 32'(st), 32'hF0);
        cmd1(8'h06);
        wr(8'h25, 8'h81);
        wp_n = 1'b0;
        wait_clk(WAIT_W);
        wp_n = 1'b1;
        rd(8'h25, d);
        check("R9 inhibit after start has no effect", 32'(d), 32'h81);

        // R10: pause mid transaction
        cs_lo();
        xfer(8'h03, d);
        hold_n = 1'b0;
        wait_clk(HALF);
        check("R10 output disabled while paused", 32'(so_oe), 32'd0);
        for (int p = 0; p < 3; p++) begin
            si = ~si;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
            wait_clk(HALF);
        end
        hold_n = 1'b1;
        wait_clk(HALF);
        check("R10 output back after resume", 32'(so_oe), 32'd1);
        xfer(8'h10, d);
        xfer(8'h00, d);
        cs_hi();
        check("R10 transaction intact after pause", 32'(d), 32'hA5);

        // R11: trailing bit discards the write; deselect disables output
        cmd1(8'h06);
        cs_lo();
        xfer(8'h02, d);
        xfer(8'h26, d);
        xfer(8'h77, d);
        si = 1'b1;
        wait_clk(HALF);
        sck = 1'b1;
        wait_clk(HALF);
        sck = 1'b0;
        cs_hi();
        check("R11 output disabled when deselected", 32'(so_oe), 32'd0);
        rdsr(st);
        check("R11 trailing bit: no timer, enable clear", 32'(st), 32'hF0);
        wait_clk(WAIT_W);
        rd(8'h26, d);
        check("R11 trailing bit: array unchanged", 32'(d), 32'h00);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule